// File: doc/BRIEF.md
# Serial flash status-register protection unit

This block holds the status register and decides write protection for the command decoder of a serial NOR flash. The serial front end hands it one decoded command at a time: enable writes, disable writes, write the status register with a data byte, program a page at an address, erase a sector at an address, or erase the whole array. The block answers each modifying command with an accept or reject decision and an address-protection flag. An accepted command starts a cycle in the array sequencer, which reports completion on a done strobe. The status byte is always present on an output so the front end can shift it out for a read-status request.

Commands arrive on a valid/ready channel. A transfer happens on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for as long as a cycle is in progress. A command offered during that time is not taken, and the source may hold it or drop it. The response channel has no back-pressure. `resp_valid` pulses for one cycle, one clock after the transfer of a status-write, program, sector-erase or bulk-erase command. The non-volatile fields are held in flops that reset to zero. The array is 2^ADDR_W bytes in sectors of 2^SECT_W bytes, which by default is 128 sectors of 64 KB.

Top module: `sf_status_guard`

## Requirements
- R1: After reset, the status byte is 0x00, `cmd_ready` is 1 and `resp_valid` is 0.
- R2: The status byte is laid out as bit7 SRWD, bit6 BP[3], bit5 TB, bits4:2 BP[2:0], bit1 WEL, bit0 WIP. Op 1 (write enable) sets WEL. Op 2 (write disable) clears WEL. Neither op produces a response.
- R3: When WEL is 0, op 3 (status write), op 4 (page program), op 5 (sector erase) and op 6 (bulk erase) are rejected. A rejected command leaves WEL and every other status bit unchanged.
- R4: An accepted status write loads the fields from the data byte using the status layout of R2: SRWD from bit7, BP[3] from bit6, TB from bit5 and BP[2:0] from bits4:2. Data bits 1:0 are ignored.
- R5: Hardware lock holds while SRWD is 1 and `wp_n` is 0. Under the lock, a status write is rejected with `resp_prot` = 1 and SRWD, TB and BP stay unchanged. With `wp_n` high the same write is accepted.
- R6: For BP = n, the protected region covers 2^(n-1) sectors when n is between 1 and the sector-index width. It covers the whole array when n is larger than that, and nothing when n is 0. A program or sector erase whose address falls inside the region is rejected with `resp_prot` = 1.
- R7: With TB = 0 the protected region ends at the highest sector. With TB = 1 it starts at sector 0.
- R8: A bulk erase is accepted only when WEL is 1 and BP is 0. Otherwise it is rejected with `resp_prot` set when BP is nonzero.
- R9: An accepted command makes WIP 1 in the same clock that `resp_valid` rises. The first `seq_done` that follows clears both WIP and WEL at the next edge.
- R10: While WIP is 1, `cmd_ready` is 0, offered commands change nothing and produce no response. A `seq_done` that arrives while WIP is 0 is ignored.
- R11: `resp_valid` rises exactly one clock after the transfer of ops 3 to 6. It carries `resp_op` equal to the op and `resp_accept` equal to WEL AND NOT `resp_prot`. Ops 0, 1, 2 and 7 produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (no cycle running) |
| cmd_op | input | 3 | Command code: 0 none, 1 write enable, 2 write disable, 3 status write, 4 program, 5 sector erase, 6 bulk erase, 7 read status |
| cmd_addr | input | ADDR_W | Byte address for program and sector erase |
| cmd_data | input | 8 | Data byte for status write |
| wp_n | input | 1 | Active-low write-protect pin |
| seq_done | input | 1 | Sequencer reports the running cycle finished |
| status | output | 8 | Status byte |
| resp_valid | output | 1 | Decision pulse |
| resp_op | output | 3 | Command code the decision belongs to |
| resp_accept | output | 1 | Command accepted, cycle started |
| resp_prot | output | 1 | Refused by protection (region hit, nonzero BP for bulk erase, or hardware lock) |

## Verification
Two situations are hard to reach from the ports: the boundary sectors of the protected region for every BP value in both TB orientations, and the hardware lock. Each boundary case needs a full write-enable, status-write, done sequence before the probe, and another write enable before each probe. The stimulus loops over all 16 BP values and both TB settings. For each setting it aims programs at the first and last byte of the sectors on either side of the bottom and top region edges. It then sets SRWD, pulls `wp_n` low, retries the status write, and offers commands while a cycle is held open by delaying `seq_done`.

// File: rtl/sfsg_pkg.sv
package sfsg_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_WREN   = 3'd1,
    OP_WRDI   = 3'd2,
    OP_WRSR   = 3'd3,
    OP_PROG   = 3'd4,
    OP_SERASE = 3'd5,
    OP_BERASE = 3'd6,
    OP_RDSR   = 3'd7
  } sfsg_op_e;

  typedef struct packed {
    logic       srwd;
    logic [3:0] bp;
    logic       tb;
  } sfsg_nv_t;

  function automatic logic [7:0] pack_status(sfsg_nv_t nv, logic wel, logic wip);
    return {nv.srwd, nv.bp[3], nv.tb, nv.bp[2:0], wel, wip};
  endfunction

  function automatic sfsg_nv_t nv_from_byte(logic [7:0] d);
    sfsg_nv_t r;
    r.srwd = d[7];
    r.bp   = {d[6], d[4:2]};
    r.tb   = d[5];
    return r;
  endfunction

endpackage

// File: rtl/sfsg_region.sv
module sfsg_region #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sector,
  input  logic [3:0]       bp,
  input  logic             tb,
  output logic             hit
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] NSECT = CNT_W'(1) << IDX_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] sec_w;
  logic             in_bottom;
  logic             in_top;

  always_comb begin
    cnt = '0;
    if (bp != 4'd0) begin
      if (int'(bp) - 1 >= IDX_W) cnt = NSECT;
      else                       cnt = CNT_W'(1) << (int'(bp) - 1);
    end
  end

  assign sec_w     = {1'b0, sector};
  assign in_bottom = sec_w < cnt;
  assign in_top    = sec_w >= (NSECT - cnt);
  assign hit       = tb ? in_bottom : in_top;

  AST_NO_HIT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bp == 4'd0) |-> !hit) else $error("region hit with BP zero"); // R6

  AST_EDGE_SECTORS: assert property (@(posedge clk) disable iff (!rst_n)
    (bp != 4'd0 && hit && !tb) |-> sector != '0 || int'(bp) - 1 >= IDX_W)
    else $error("top region reached sector zero"); // R7

endmodule

// File: rtl/sfsg_status_regs.sv
module sfsg_status_regs
  import sfsg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_wel,
  input  logic     clr_wel,
  input  logic     start_cycle,
  input  logic     nv_we,
  input  sfsg_nv_t nv_d,
  input  logic     seq_done,
  output sfsg_nv_t nv,
  output logic     wel,
  output logic     wip
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv  <= '0;
      wel <= 1'b0;
      wip <= 1'b0;
    end else if (wip) begin
      if (seq_done) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end
    end else begin
      if (start_cycle) wip <= 1'b1;
      if (set_wel)     wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
      if (nv_we)       nv  <= nv_d;
    end
  end

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && seq_done) |=> (!wip && !wel)) else $error("done did not clear"); // R9

endmodule

// File: rtl/sf_status_guard.sv
module sf_status_guard
  import sfsg_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int SECT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic              seq_done,
  output logic [7:0]        status,
  output logic              resp_valid,
  output logic [2:0]        resp_op,
  output logic              resp_accept,
  output logic              resp_prot
);
  localparam int IDX_W = ADDR_W - SECT_W;

  sfsg_nv_t nv;
  logic     wel, wip;
  logic     fire, hw_lock, region_hit;
  logic     is_mod, prot_now, accept_now;
  logic     unused_bits;

  assign unused_bits = &{1'b0, cmd_addr[SECT_W-1:0], cmd_data[1:0]};

  assign cmd_ready = !wip;
  assign fire      = cmd_valid && cmd_ready;
  assign hw_lock   = nv.srwd && !wp_n;

  sfsg_region #(.IDX_W(IDX_W)) u_region (
    .clk    (clk),
    .rst_n  (rst_n),
    .sector (cmd_addr[ADDR_W-1:SECT_W]),
    .bp     (nv.bp),
    .tb     (nv.tb),
    .hit    (region_hit)
  );

  always_comb begin
    is_mod   = 1'b0;
    prot_now = 1'b0;
    unique case (sfsg_op_e'(cmd_op))
      OP_WRSR:   begin is_mod = 1'b1; prot_now = hw_lock;          end
      OP_PROG,
      OP_SERASE: begin is_mod = 1'b1; prot_now = region_hit;       end
      OP_BERASE: begin is_mod = 1'b1; prot_now = (nv.bp != 4'd0);  end
      default:   ;
    endcase
    accept_now = is_mod && wel && !prot_now;
  end

  sfsg_status_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_wel     (fire && cmd_op == OP_WREN),
    .clr_wel     (fire && cmd_op == OP_WRDI),
    .start_cycle (fire && accept_now),
    .nv_we       (fire && accept_now && cmd_op == OP_WRSR),
    .nv_d        (nv_from_byte(cmd_data)),
    .seq_done    (seq_done),
    .nv          (nv),
    .wel         (wel),
    .wip         (wip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_op     <= OP_NONE;
      resp_accept <= 1'b0;
      resp_prot   <= 1'b0;
    end else begin
      resp_valid <= fire && is_mod;
      if (fire && is_mod) begin
        resp_op     <= cmd_op;
        resp_accept <= accept_now;
        resp_prot   <= prot_now;
      end
    end
  end

  assign status = pack_status(nv, wel, wip);

  AST_ACCEPT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_accept) |-> $past(wel)) else $error("accept without WEL"); // R3
  AST_REJECT_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_accept) |-> $stable(wel)) else $error("reject changed WEL"); // R3
  AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (nv.srwd && !wp_n) |=> $stable(nv)) else $error("locked fields changed"); // R5
  AST_BULK_NEEDS_ZERO_BP: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_accept && resp_op == OP_BERASE) |-> (nv.bp == 4'd0))
    else $error("bulk erase with BP set"); // R8
  AST_ACCEPT_RAISES_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_accept) |-> wip) else $error("accept without WIP"); // R9
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !seq_done) |=> ($stable(nv) && $stable(wel) && !resp_valid))
    else $error("state moved while busy"); // R10

endmodule

// File: tb/tb_sf_status_guard.sv
module tb_sf_status_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;
  localparam int SW = 16;
  localparam int NSEC = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = 8'd0;
  logic          wp_n = 1'b1;
  logic          seq_done = 1'b0;
  logic [7:0]    status;
  logic          resp_valid, resp_accept, resp_prot;
  logic [2:0]    resp_op;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sf_status_guard #(.ADDR_W(AW), .SECT_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
    .seq_done(seq_done), .status(status), .resp_valid(resp_valid),
    .resp_op(resp_op), .resp_accept(resp_accept), .resp_prot(resp_prot)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit m_wel = 0, m_wip = 0, m_srwd = 0, m_tb = 0;
  bit [3:0] m_bp = 0;
  bit m_rv = 0, m_ra = 0, m_rp = 0;
  bit [2:0] m_rop = 0;

  function automatic bit ref_hit(logic [AW-1:0] a, bit [3:0] bp, bit tb);
    int s = int'(a) / (1 << SW);
    int n;
    if (bp == 0) return 0;
    n = (bp >= 8) ? NSEC : (1 << (bp - 1));
    return tb ? (s < n) : (s >= NSEC - n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wel = 0; m_wip = 0; m_srwd = 0; m_tb = 0; m_bp = 0;
      m_rv = 0; m_ra = 0; m_rp = 0; m_rop = 0;
    end else begin
      bit p, a, mod;
      p = 0; mod = 0;
      m_rv = 0;
      if (m_wip) begin
        if (seq_done) begin m_wip = 0; m_wel = 0; end
      end else if (cmd_valid) begin
        case (cmd_op)
          3'd1: m_wel = 1;
          3'd2: m_wel = 0;
          3'd3: begin mod = 1; p = m_srwd && !wp_n; end
          3'd4, 3'd5: begin mod = 1; p = ref_hit(cmd_addr, m_bp, m_tb); end
          3'd6: begin mod = 1; p = (m_bp != 0); end
          default: ;
        endcase
        if (mod) begin
          a = m_wel && !p;
          m_rv = 1; m_ra = a; m_rp = p; m_rop = cmd_op;
          if (a) begin
            m_wip = 1;
            if (cmd_op == 3'd3) begin
              m_srwd = cmd_data[7]; m_tb = cmd_data[5];
              m_bp = {cmd_data[6], cmd_data[4:2]};
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk("R2 R4 status", status, {m_srwd, m_bp[3], m_tb, m_bp[2:0], m_wel, m_wip});
      chk("R10 cmd_ready", cmd_ready, !m_wip);
      chk("R11 resp_valid", resp_valid, m_rv);
      if (m_rv) begin
        chk("R11 resp_op", resp_op, m_rop);
        chk("R3 R6 resp_accept", resp_accept, m_ra);
        chk("R6 R8 resp_prot", resp_prot, m_rp);
      end
    end
  end

  task automatic issue(int op, logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic done_pulse();
    @(negedge clk); seq_done = 1'b1;
    @(negedge clk); seq_done = 1'b0;
  endtask

  function automatic logic [7:0] sr_byte(bit srwd, bit [3:0] bp, bit tb);
    return {srwd, bp[3], tb, bp[2:0], 2'b00};
  endfunction

  function automatic logic [AW-1:0] sec_addr(int s, bit high);
    if (s < 0) s = 0;
    if (s > NSEC - 1) s = NSEC - 1;
    return AW'(s * (1 << SW) + (high ? (1 << SW) - 1 : 0));
  endfunction

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 0);
    chk("R1 reset ready", cmd_ready, 1);
    chk("R1 reset resp_valid", resp_valid, 0);
    rst_n = 1'b1;

    // R3: no WEL -> reject
    issue(4, 0, 0);
    chk("R3 reject no WEL", {resp_valid, resp_accept}, 2'b10);
    issue(1, 0, 0);
    chk("R2 WEL set", status, 8'h02);
    issue(2, 0, 0);
    chk("R2 WEL cleared", status, 8'h00);

    // R4 R9: status write, busy, done
    issue(1, 0, 0);
    issue(3, 0, 8'h0F);
    chk("R4 R9 status after write", status, 8'h0F);
    issue(1, 0, 0);
    chk("R10 command ignored while busy", status, 8'h0F);
    done_pulse();
    chk("R9 done clears WIP WEL", status, 8'h0C);
    done_pulse();
    chk("R10 idle done ignored", status, 8'h0C);

    // R6 R7: region sweep
    for (int tb = 0; tb < 2; tb++) begin
      for (int bp = 0; bp < 16; bp++) begin
        int n;
        int sl [8];
        issue(1, 0, 0);
        issue(3, 0, sr_byte(0, 4'(bp), 1'(tb)));
        done_pulse();
        n = (bp == 0) ? 0 : (bp >= 8 ? NSEC : (1 << (bp - 1)));
        sl = '{0, n - 1, n, NSEC - n - 1, NSEC - n, NSEC - 1, 63, 64};
        for (int k = 0; k < 16; k++) begin
          logic [AW-1:0] a;
          bit exp_acc;
          a = sec_addr(sl[k/2], 1'(k % 2));
          exp_acc = !ref_hit(a, 4'(bp), 1'(tb));
          issue(1, 0, 0);
          issue((k % 3 == 0) ? 5 : 4, a, 0);
          chk(tb ? "R7 bottom edge accept" : "R6 top edge accept", resp_accept, exp_acc);
          if (exp_acc) done_pulse(); else issue(2, 0, 0);
        end
      end
    end

    // R8: bulk erase with BP nonzero, then zero
    issue(1, 0, 0);
    issue(3, 0, sr_byte(0, 4'd2, 0));
    done_pulse();
    issue(1, 0, 0);
    issue(6, 0, 0);
    chk("R8 bulk rejected BP set", {resp_accept, resp_prot}, 2'b01);
    chk("R3 WEL kept after reject", status[1], 1);
    issue(3, 0, sr_byte(0, 4'd0, 0));
    done_pulse();
    issue(1, 0, 0);
    issue(6, 0, 0);
    chk("R8 bulk accepted BP zero", {resp_accept, resp_prot}, 2'b10);
    done_pulse();

    // R5: hardware lock
    issue(1, 0, 0);
    issue(3, 0, sr_byte(1, 4'd1, 1));
    done_pulse();
    wp_n = 1'b0;
    issue(1, 0, 0);
    issue(3, 0, 8'h00);
    chk("R5 locked write rejected", {resp_accept, resp_prot}, 2'b01);
    chk("R5 locked fields unchanged", status, 8'hA6);
    wp_n = 1'b1;
    issue(3, 0, 8'h00);
    chk("R5 unlocked write accepted", resp_accept, 1);
    done_pulse();
    chk("R5 fields cleared", status, 8'h00);

    // R11: no response for non-modifying ops
    issue(7, 0, 0);
    chk("R11 no resp for read status", resp_valid, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule